// File: doc/BRIEF.md
# PWM Channel with Deferred Parameter Update

This block produces one pulse-width-modulated output from a free-running count that advances on a prescaled clock-enable strobe. Software configures it through a narrow write port. The write port selects one of four targets:

- the period value,
- the duty value,
- a pending-update value,
- a four-bit mode word.

While the channel is stopped, period, duty and mode are loaded directly. Once the channel runs, those three are frozen. The only way to change a waveform parameter is then the pending-update value. It is held until the current waveform cycle ends and then replaces either the period or the duty, as a mode bit selects. Because of this, a running waveform never shows a partial or torn cycle.

A small sequencer drives the count. It has four named states:

- `ST_IDLE`: stopped; the count is held at 0.
- `ST_LEFT`: left-aligned; counts up and wraps.
- `ST_RISE`: centre-aligned, rising half.
- `ST_FALL`: centre-aligned, falling half.

The transitions are:

- `start` moves `ST_IDLE` to `ST_LEFT` or `ST_RISE`, depending on the alignment bit.
- `ST_LEFT` wraps back to itself on the last count of the period. This is a cycle boundary.
- `ST_RISE` moves to `ST_FALL` at the top count.
- `ST_FALL` moves to `ST_RISE` at count 0. This is a cycle boundary.
- `stop` returns any state to `ST_IDLE`.

Each cycle boundary sets a sticky interrupt flag. Several instances that receive the same `start` pulse begin counting on the same edge.

Top module: `pwm_channel`

## Requirements
- R1: After reset the channel is stopped, `pwm_out` is 0 and `irq` is 0. The mode word resets to 0.
- R2: Writes to the period (`wr_sel`=0) or duty (`wr_sel`=1) take effect only while the channel is stopped. While it runs, such writes leave the waveform unchanged.
- R3: In left alignment (mode bit 0 = 0) the count runs 0 to period-1 and wraps, one step per tick. The output is active while the count is below the duty value.
- R4: In centre alignment (mode bit 0 = 1) the count rises 0 to period-1, holds that value for one more tick while turning, and falls back to 0. One cycle is therefore 2×period ticks. The output is active while the count is below the duty value.
- R5: Mode bit 1 selects the active level: 0 = active high, 1 = active low. While stopped, the output sits at the inactive level.
- R6: A duty of 0 gives a never-active output. A duty equal to or above the period gives an always-active output.
- R7: A write to the update value (`wr_sel`=2) while running is applied at the next cycle boundary. It goes to the duty if mode bit 2 is 1, and to the period if mode bit 2 is 0. An update write while stopped is dropped.
- R8: The count and the sequencer state advance only in cycles where `tick` is 1.
- R9: A cycle boundary sets a sticky flag, and `irq_ack` clears it. A boundary in the same cycle as `irq_ack` leaves the flag set. `irq` is the flag ANDed with mode bit 3.
- R10: `stop` returns the channel to `ST_IDLE` with count 0 and discards any pending update. `stop` overrides a simultaneous `start`.
- R11: Two channels given the same `start` pulse, period and alignment cross every cycle boundary on the same clock edge.
- R12: Mode writes (`wr_sel`=3, data bits 3:0) are accepted only while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled clock-enable that advances the count |
| start | input | 1 | Pulse that starts the channel from stopped |
| stop | input | 1 | Pulse that stops the channel; overrides start |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 update, 3 mode |
| wr_data | input | CW | Write data |
| irq_ack | input | 1 | Clears the sticky boundary flag |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Boundary flag gated by the interrupt-enable bit |

## Verification
The hardest situation to reach from the ports is an update that is pending when the channel is stopped just before the boundary that would have applied it. The update must vanish, so that the restarted waveform still uses the old duty. The stimulus starts a run and writes the update in the first running cycle. It then pulses `stop` a few counts before the period ends, restarts, and compares a full period cycle by cycle. A second case drives `start` and `stop` together on a running channel. Another holds `irq_ack` high while a period of 1 produces a boundary on every tick, so a boundary and an acknowledge fall in the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEFT = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } pwm_state_e;

    // Mode word, bit 3 down to bit 0
    typedef struct packed {
        logic irq_en;    // bit 3
        logic upd_duty;  // bit 2: update targets duty (1) or period (0)
        logic act_low;   // bit 1: active level is low
        logic centre;    // bit 0: centre alignment
    } pwm_mode_t;

    localparam int MODE_W = $bits(pwm_mode_t);

    localparam logic [1:0] SEL_PRD  = 2'd0;
    localparam logic [1:0] SEL_DTY  = 2'd1;
    localparam logic [1:0] SEL_UPD  = 2'd2;
    localparam logic [1:0] SEL_MODE = 2'd3;

endpackage

// File: rtl/pwm_cfg.sv
module pwm_cfg
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked,
    input  logic          boundary,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] prd,
    output logic [CW-1:0] dty,
    output pwm_mode_t     mode,
    output logic          pend
);

    logic [CW-1:0] upd_val;
    logic          upd_wr;

    assign upd_wr = wr_en && (wr_sel == SEL_UPD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd     <= '0;
            dty     <= '0;
            mode    <= '0;
            upd_val <= '0;
            pend    <= 1'b0;
        end else if (!locked) begin
            pend <= 1'b0;
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_PRD:  prd  <= wr_data;
                    SEL_DTY:  dty  <= wr_data;
                    SEL_MODE: mode <= pwm_mode_t'(wr_data[MODE_W-1:0]);
                    default:  ;
                endcase
            end
        end else begin
            if (boundary && pend) begin
                if (mode.upd_duty) begin
                    dty <= upd_val;
                end else begin
                    prd <= upd_val;
                end
            end
            if (upd_wr) begin
                upd_val <= wr_data;
                pend    <= 1'b1;
            end else if (boundary) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          tick,
    input  logic          centre,
    input  logic [CW-1:0] prd,
    output pwm_state_e    state,
    output logic [CW-1:0] cnt,
    output logic          boundary
);

    localparam logic [CW-1:0] ONE = CW'(1);

    pwm_state_e    nxt_state;
    logic [CW-1:0] nxt_cnt;
    logic [CW-1:0] prd_m1;
    logic          wrap;

    assign prd_m1 = prd - ONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Next-state and count
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        wrap      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_cnt = '0;
                if (start) begin
                    nxt_state = centre ? ST_RISE : ST_LEFT;
                end
            end
            ST_LEFT: begin
                if (tick) begin
                    if (cnt == prd_m1) begin
                        nxt_cnt = '0;
                        wrap    = 1'b1;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            ST_RISE: begin
                if (tick) begin
                    if (cnt == prd_m1) begin
                        nxt_state = ST_FALL;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            ST_FALL: begin
                if (tick) begin
                    if (cnt == '0) begin
                        nxt_state = ST_RISE;
                        wrap      = 1'b1;
                    end else begin
                        nxt_cnt = cnt - ONE;
                    end
                end
            end
        endcase
        if (stop) begin
            nxt_state = ST_IDLE;
            nxt_cnt   = '0;
            wrap      = 1'b0;
        end
    end

    assign boundary = wrap;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pwm_state_e    state,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] dty,
    input  logic          act_low,
    input  logic          irq_en,
    input  logic          boundary,
    input  logic          irq_ack,
    output logic          irq_flag,
    output logic          pwm_out,
    output logic          irq
);

    logic active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (boundary) begin
            irq_flag <= 1'b1;
        end else if (irq_ack) begin
            irq_flag <= 1'b0;
        end
    end

    // Output process
    always_comb begin
        active  = (state != ST_IDLE) && (cnt < dty);
        pwm_out = active ? ~act_low : act_low;
        irq     = irq_flag & irq_en;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          stop,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          irq_ack,
    output logic          pwm_out,
    output logic          irq
);

    pwm_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] prd;
    logic [CW-1:0] dty;
    pwm_mode_t     mode;
    logic          pend;
    logic          boundary;
    logic          locked;
    logic          irq_flag;

    assign locked = (state != ST_IDLE) && !stop;

    pwm_cfg #(.CW(CW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (locked),
        .boundary (boundary),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .prd      (prd),
        .dty      (dty),
        .mode     (mode),
        .pend     (pend)
    );

    pwm_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stop     (stop),
        .tick     (tick),
        .centre   (mode.centre),
        .prd      (prd),
        .state    (state),
        .cnt      (cnt),
        .boundary (boundary)
    );

    pwm_out_stage #(.CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cnt      (cnt),
        .dty      (dty),
        .act_low  (mode.act_low),
        .irq_en   (mode.irq_en),
        .boundary (boundary),
        .irq_ack  (irq_ack),
        .irq_flag (irq_flag),
        .pwm_out  (pwm_out),
        .irq      (irq)
    );

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          stop,
    input logic          irq_ack,
    input logic          pwm_out,
    input pwm_state_e    state,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] prd,
    input logic [CW-1:0] dty,
    input pwm_mode_t     mode,
    input logic          pend,
    input logic          boundary,
    input logic          irq_flag
);

    AST_DIRECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !stop && !boundary) |=> ($stable(prd) && $stable(dty))); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && prd != '0) |-> (cnt < prd)); // R3

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pwm_out == mode.act_low)); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !tick && !stop) |=> ($stable(cnt) && $stable(state))); // R8

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> irq_flag); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_ack) |=> irq_flag); // R9

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && cnt == '0 && !pend)); // R10

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !stop) |=> $stable(mode)); // R12

endmodule

bind pwm_channel pwm_channel_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .stop     (stop),
    .irq_ack  (irq_ack),
    .pwm_out  (pwm_out),
    .state    (state),
    .cnt      (cnt),
    .prd      (prd),
    .dty      (dty),
    .mode     (mode),
    .pend     (pend),
    .boundary (boundary),
    .irq_flag (irq_flag)
);

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;

    localparam int CW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, tick, start, stop, wr_en, wr_en2, irq_ack;
    logic [1:0]    wr_sel;
    logic [CW-1:0] wr_data;
    logic          pwm_out, irq, pwm_out2, irq2;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    e1;
        bit    c2;
        bit    e2;
        string req;
    } item_t;

    item_t q[$];

    pwm_channel #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
        .pwm_out(pwm_out), .irq(irq)
    );

    pwm_channel #(.CW(CW)) dut2 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
        .wr_en(wr_en2), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(1'b0),
        .pwm_out(pwm_out2), .irq(irq2)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Expected output level from the requirements (R3, R4, R5, R6)
    function automatic bit exp_level(bit centre, int prd, int dty, bit al, int i);
        int c;
        int p;
        if (centre) begin
            p = i % (2 * prd);
            c = (p < prd) ? p : (2 * prd - 1 - p);
        end else begin
            c = i % prd;
        end
        return (c < dty) ^ al;
    endfunction

    // Driver side of the scoreboard: one item per clock after the push edge
    task automatic push_seg(bit centre, int prd, int dty, bit al, int i0, int n,
                            string req, bit c2 = 1'b0, int dty2 = 0);
        item_t it;
        for (int i = 0; i < n; i++) begin
            it.e1  = exp_level(centre, prd, dty, al, i0 + i);
            it.c2  = c2;
            it.e2  = exp_level(centre, prd, dty2, al, i0 + i);
            it.req = req;
            q.push_back(it);
        end
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            chk(pwm_out, it.e1, it.req);
            if (it.c2) chk(pwm_out2, it.e2, {it.req, " second channel"});
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drain();
        wait (q.size() == 0);
        step();
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = CW'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic wr2(input logic [1:0] sel, input int data);
        wr_en2 = 1'b1; wr_sel = sel; wr_data = CW'(data);
        step();
        wr_en2 = 1'b0;
    endtask

    task automatic begin_run();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic stop_run();
        stop = 1'b1;
        step();
        stop = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; start = 1'b0; stop = 1'b0;
        wr_en = 1'b0; wr_en2 = 1'b0; irq_ack = 1'b0;
        wr_sel = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        sample();
        chk(pwm_out, 1'b0, "R1 reset output");
        chk(irq, 1'b0, "R1 reset irq");

        // R3 left-aligned base waveform, direct loads while stopped (R2)
        step();
        wr(pwm_pkg::SEL_PRD, 8);
        wr(pwm_pkg::SEL_DTY, 3);
        begin_run();
        push_seg(0, 8, 3, 0, 0, 16, "R3 left aligned");
        drain();
        stop_run();
        sample();
        chk(pwm_out, 1'b0, "R10 stopped output inactive");

        // R2 direct writes ignored while running
        begin_run();
        push_seg(0, 8, 3, 0, 0, 16, "R2 direct write ignored");
        wr(pwm_pkg::SEL_DTY, 6);
        wr(pwm_pkg::SEL_PRD, 5);
        drain();
        stop_run();

        // R7 update targets duty
        wr(pwm_pkg::SEL_MODE, 4'b0100);
        begin_run();
        push_seg(0, 8, 3, 0, 0, 8, "R7 before duty update");
        push_seg(0, 8, 6, 0, 0, 16, "R7 after duty update");
        wr(pwm_pkg::SEL_UPD, 6);
        drain();
        stop_run();

        // R7 update targets period, result saturated (R6)
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        begin_run();
        push_seg(0, 8, 6, 0, 0, 8, "R7 before period update");
        push_seg(0, 4, 6, 0, 0, 8, "R6 duty above period saturates");
        wr(pwm_pkg::SEL_UPD, 4);
        drain();
        stop_run();

        // R6 zero duty
        wr(pwm_pkg::SEL_DTY, 0);
        begin_run();
        push_seg(0, 4, 0, 0, 0, 8, "R6 zero duty never active");
        drain();
        stop_run();

        // R4 centre aligned
        wr(pwm_pkg::SEL_MODE, 4'b0001);
        wr(pwm_pkg::SEL_PRD, 5);
        wr(pwm_pkg::SEL_DTY, 2);
        begin_run();
        push_seg(1, 5, 2, 0, 0, 20, "R4 centre aligned");
        drain();
        stop_run();

        // R5 active-low polarity; R12 mode write ignored while running
        wr(pwm_pkg::SEL_MODE, 4'b0011);
        begin_run();
        push_seg(1, 5, 2, 1, 0, 10, "R5 active low");
        push_seg(1, 5, 2, 1, 10, 10, "R12 mode write ignored while running");
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        drain();
        stop_run();
        sample();
        chk(pwm_out, 1'b1, "R5 stopped at inactive high level");
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        sample();
        chk(pwm_out, 1'b0, "R12 mode write accepted while stopped");

        // R7 update while stopped dropped; R10 pending update discarded by stop
        wr(pwm_pkg::SEL_MODE, 4'b0100);
        wr(pwm_pkg::SEL_UPD, 4);
        begin_run();
        push_seg(0, 5, 2, 0, 0, 3, "R7 stopped update dropped");
        wr(pwm_pkg::SEL_UPD, 4);
        drain();
        stop_run();
        begin_run();
        push_seg(0, 5, 2, 0, 0, 10, "R10 pending update discarded");
        drain();
        start = 1'b1; stop = 1'b1;
        step();
        start = 1'b0; stop = 1'b0;
        sample();
        chk(pwm_out, 1'b0, "R10 stop overrides start");
        repeat (3) step();
        sample();
        chk(pwm_out, 1'b0, "R10 channel stays stopped");

        // R8 count advances only on tick
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        wr(pwm_pkg::SEL_DTY, 1);
        tick = 1'b0;
        begin_run();
        for (int k = 0; k < 6; k++) push_seg(0, 5, 1, 0, 0, 1, "R8 count held without tick");
        drain();
        tick = 1'b1;
        push_seg(0, 5, 1, 0, 0, 10, "R8 count resumes with tick");
        drain();
        stop_run();

        // R9 interrupt flag
        wr(pwm_pkg::SEL_MODE, 4'b1000);
        wr(pwm_pkg::SEL_PRD, 3);
        begin_run();
        push_seg(0, 3, 1, 0, 0, 6, "R9 run with irq enabled");
        drain();
        stop_run();
        sample();
        chk(irq, 1'b1, "R9 flag set after boundary");
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        sample();
        chk(irq, 1'b0, "R9 flag cleared by ack");
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        begin_run();
        push_seg(0, 3, 1, 0, 0, 4, "R9 run with irq disabled");
        drain();
        stop_run();
        sample();
        chk(irq, 1'b0, "R9 irq gated by enable bit");
        wr(pwm_pkg::SEL_MODE, 4'b1000);
        sample();
        chk(irq, 1'b1, "R9 flag stayed sticky while gated");
        wr(pwm_pkg::SEL_PRD, 1);
        begin_run();
        irq_ack = 1'b1;
        step();
        step();
        sample();
        chk(irq, 1'b1, "R9 boundary beats ack");
        irq_ack = 1'b0;
        stop_run();

        // R11 lockstep start of two channels
        wr(pwm_pkg::SEL_MODE, 4'b0000);
        wr(pwm_pkg::SEL_PRD, 6);
        wr(pwm_pkg::SEL_DTY, 2);
        wr2(pwm_pkg::SEL_PRD, 6);
        wr2(pwm_pkg::SEL_DTY, 4);
        begin_run();
        push_seg(0, 6, 2, 0, 0, 18, "R11 lockstep", 1'b1, 4);
        drain();
        stop_run();

        finish_run();
    end

endmodule